// File: doc/BRIEF.md
# Broadcast Coherence Miss Controller

This block handles cache misses for one tile of a tiled multicore whose coherence scheme broadcasts requests. When the local cache reports a miss, the controller sends a request message to the home tile of the missing block. The home tile then forwards the request to every other tile. Each of those tiles answers this controller directly, with either an acknowledgement or a data message.

The responses travel over an unordered point-to-point network, so they can arrive in any order. The data message, if there is one, can come before, between or after the acknowledgements. The controller counts the responses that belong to the outstanding miss. When the last one is in, it does two things: it gives the cache a one-cycle completion pulse with the data, and it sends an unblock message to the home tile. If every response was an acknowledgement, the completion pulse instead carries a flag telling the cache to fetch the block from memory.

Only one miss is outstanding per tile. Messages that do not belong to the outstanding miss are consumed and counted in an error counter.

Top module: `bcast_miss_ctrl`

## Requirements
- R1: After reset the controller is ready for a miss (`miss_ready`=1), `tx_valid`=0, `done_valid`=0 and `err_count`=0.
- R2: The cycle after a miss is accepted, the controller offers a request with `tx_type`=1. It has `tx_dst` = (address >> OFFS_W) mod N_TILES, `tx_src` = MY_TILE and `tx_addr` = the miss address.
- R3: `miss_ready` stays 0 from the accepted miss until the unblock message has been accepted. It returns to 1 in the cycle after that acceptance.
- R4: `done_valid` pulses for exactly one cycle. The pulse comes in the cycle after the (N_TILES-1)-th matching response, and never earlier, whatever the order of the responses.
- R5: In the cycle after the last response, the controller offers an unblock message with `tx_type`=4, addressed to the same home tile and carrying the miss address.
- R6: A matching response with `rx_type`=3 (data) delivers its `rx_data` on `done_data`, with `done_from_mem`=0, whatever its position among the responses.
- R7: If all matching responses have `rx_type`=2 (acknowledge), the completion shows `done_from_mem`=1 and `done_data`=0.
- R8: A received message is dropped and adds one to `err_count`, which saturates at all ones, in any of these cases: it arrives while no response is awaited; its address differs from the miss; its `rx_dst` is not MY_TILE; its `rx_src` is MY_TILE; or its type is not 2 or 3. A dropped message does not advance the response count.
- R9: `rx_ready` is 1 in every cycle, so incoming messages are always consumed.
- R10: While `tx_valid`=1 and `tx_ready`=0, the offered message stays valid and its type, destination and address do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a miss |
| miss_ready | output | 1 | Controller accepts a miss |
| miss_addr | input | ADDR_W | Address of the missing block |
| tx_valid | output | 1 | Outgoing message valid |
| tx_ready | input | 1 | Network accepts outgoing message |
| tx_type | output | 3 | Outgoing type: 1 request, 4 unblock |
| tx_src | output | TID_W | Sending tile (MY_TILE) |
| tx_dst | output | TID_W | Destination tile (home) |
| tx_addr | output | ADDR_W | Block address |
| tx_data | output | DATA_W | Payload, always zero |
| rx_valid | input | 1 | Incoming message valid |
| rx_ready | output | 1 | Incoming message consumed |
| rx_type | input | 3 | Incoming type: 2 acknowledge, 3 data |
| rx_src | input | TID_W | Responding tile |
| rx_dst | input | TID_W | Addressed tile |
| rx_addr | input | ADDR_W | Block address of the response |
| rx_data | input | DATA_W | Payload of a data response |
| done_valid | output | 1 | One-cycle completion pulse |
| done_data | output | DATA_W | Block data for the cache |
| done_from_mem | output | 1 | No tile supplied data; fetch from memory |
| err_count | output | ERR_W | Saturating count of dropped messages |

## Verification
The hardest case to reach from the ports is a stray message that looks like a response but must not count, arriving in the middle of the wait. Examples are an acknowledgement for another address, one addressed to another tile, or a request-type message. A wrongly counted stray would close the miss one response early. To reach this case, the bench inserts such messages between genuine responses. It sweeps the position of the data response over every slot, adds an all-acknowledgement case, and uses several network stall lengths and home tiles. Before the final genuine response, the bench checks that no completion has appeared.

// File: rtl/bcast_miss_ctrl.sv
`timescale 1ns/1ps
module bcast_miss_ctrl #(
  parameter int N_TILES = 4,
  parameter int MY_TILE = 0,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int OFFS_W  = 4,
  parameter int ERR_W   = 4,
  localparam int TID_W  = (N_TILES > 1) ? $clog2(N_TILES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [2:0]        tx_type,
  output logic [TID_W-1:0]  tx_src,
  output logic [TID_W-1:0]  tx_dst,
  output logic [ADDR_W-1:0] tx_addr,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [2:0]        rx_type,
  input  logic [TID_W-1:0]  rx_src,
  input  logic [TID_W-1:0]  rx_dst,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  output logic              done_valid,
  output logic [DATA_W-1:0] done_data,
  output logic              done_from_mem,
  output logic [ERR_W-1:0]  err_count
);
  localparam int CNT_W = TID_W;
  localparam logic [2:0] T_REQ = 3'd1, T_ACK = 3'd2, T_DATA = 3'd3, T_UNB = 3'd4;
  localparam logic [TID_W-1:0] SELF = TID_W'(MY_TILE);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_UNB} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [DATA_W-1:0] data_q;
  logic              got_q, done_q, mem_q;
  logic [ERR_W-1:0]  err_q;
  logic [ADDR_W-1:0] blk;
  logic              tx_fire, is_rsp, match, last, is_data;

  assign blk      = addr_q >> OFFS_W;
  assign tx_fire  = tx_valid & tx_ready;
  assign is_rsp   = (rx_type == T_ACK) | (rx_type == T_DATA);
  assign is_data  = rx_type == T_DATA;
  assign match    = rx_valid & (st == S_WAIT) & is_rsp & (rx_addr == addr_q)
                  & (rx_dst == SELF) & (rx_src != SELF);
  assign last     = match & (left_q == CNT_W'(1));

  assign miss_ready    = st == S_IDLE;
  assign rx_ready      = 1'b1;
  assign tx_valid      = (st == S_REQ) | (st == S_UNB);
  assign tx_type       = (st == S_UNB) ? T_UNB : T_REQ;
  assign tx_src        = SELF;
  assign tx_dst        = TID_W'(blk % ADDR_W'(N_TILES));
  assign tx_addr       = addr_q;
  assign tx_data       = '0;
  assign done_valid    = done_q;
  assign done_data     = data_q;
  assign done_from_mem = mem_q;
  assign err_count     = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      data_q <= '0;
      got_q  <= 1'b0;
      done_q <= 1'b0;
      mem_q  <= 1'b0;
      err_q  <= '0;
    end else begin
      done_q <= last;
      if (rx_valid && !match && err_q != {ERR_W{1'b1}})
        err_q <= err_q + ERR_W'(1);
      case (st)
        S_IDLE: if (miss_valid) begin
          addr_q <= miss_addr;
          st     <= S_REQ;
        end
        S_REQ: if (tx_fire) begin
          left_q <= CNT_W'(N_TILES - 1);
          data_q <= '0;
          got_q  <= 1'b0;
          st     <= S_WAIT;
        end
        S_WAIT: if (match) begin
          left_q <= left_q - CNT_W'(1);
          if (is_data) begin
            data_q <= rx_data;
            got_q  <= 1'b1;
          end
          if (last) begin
            mem_q <= !(got_q | is_data);
            st    <= S_UNB;
          end
        end
        S_UNB: if (tx_fire) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcast_miss_ctrl_chk.sv
`timescale 1ns/1ps
module bcast_miss_ctrl_chk #(
  parameter int TID_W  = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [2:0]        tx_type,
  input logic [TID_W-1:0]  tx_dst,
  input logic [ADDR_W-1:0] tx_addr,
  input logic              done_valid,
  input logic              done_from_mem,
  input logic [DATA_W-1:0] done_data,
  input logic [ERR_W-1:0]  err_count
);
  AST_REQ_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (tx_valid && tx_type == 3'd1 && !miss_ready)); // R2
  AST_NO_MISS_WHILE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !miss_ready); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R4
  AST_UNBLOCK_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (tx_valid && tx_type == 3'd4)); // R5
  AST_MEM_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_from_mem) |-> done_data == '0); // R7
  AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> err_count >= $past(err_count)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_type) && $stable(tx_dst) && $stable(tx_addr))); // R10
endmodule

bind bcast_miss_ctrl bcast_miss_ctrl_chk #(
  .TID_W(TID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_dst(tx_dst),
  .tx_addr(tx_addr), .done_valid(done_valid), .done_from_mem(done_from_mem),
  .done_data(done_data), .err_count(err_count)
);

// File: tb/bcast_miss_ctrl_tb.sv
`timescale 1ns/1ps
module bcast_miss_ctrl_tb;
  localparam int N = 4, ME = 0, AW = 16, DW = 32, OW = 4, EW = 4, TW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic miss_valid = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [AW-1:0] miss_addr = '0, rx_addr = '0;
  logic [2:0] rx_type = '0;
  logic [TW-1:0] rx_src = '0, rx_dst = '0;
  logic [DW-1:0] rx_data = '0;
  logic miss_ready, tx_valid, rx_ready, done_valid, done_from_mem;
  logic [2:0] tx_type;
  logic [TW-1:0] tx_src, tx_dst;
  logic [AW-1:0] tx_addr;
  logic [DW-1:0] tx_data, done_data;
  logic [EW-1:0] err_count;

  int checks = 0, fails = 0, exp_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bcast_miss_ctrl #(.N_TILES(N), .MY_TILE(ME), .ADDR_W(AW), .DATA_W(DW), .OFFS_W(OW), .ERR_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_type(tx_type), .tx_src(tx_src), .tx_dst(tx_dst),
    .tx_addr(tx_addr), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_type(rx_type),
    .rx_src(rx_src), .rx_dst(rx_dst), .rx_addr(rx_addr), .rx_data(rx_data), .done_valid(done_valid),
    .done_data(done_data), .done_from_mem(done_from_mem), .err_count(err_count));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_rx(input logic [2:0] t, input int src, input int dst, input logic [AW-1:0] a, input logic [DW-1:0] d);
    rx_valid = 1'b1; rx_type = t; rx_src = TW'(src); rx_dst = TW'(dst); rx_addr = a; rx_data = d;
    chk("R9 rx_ready", rx_ready, 1);
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic bump_err();
    if (exp_err < (1 << EW) - 1) exp_err++;
  endtask

  task automatic do_miss(input logic [AW-1:0] a, input int dpos, input int stall, input int bad, input int rot);
    int home;
    logic [DW-1:0] val;
    home = int'(a >> OW) % N;
    val = 32'hC0DE0000 ^ {16'h0, a};
    miss_valid = 1'b1; miss_addr = a;
    tick();
    miss_valid = 1'b0;
    chk("R3 busy after miss", miss_ready, 0);
    chk("R2 req valid", tx_valid, 1);
    chk("R2 req type", tx_type, 1);
    chk("R2 req home", tx_dst, home);
    chk("R2 req src", tx_src, ME);
    chk("R2 req addr", tx_addr, a);
    for (int s = 0; s < stall; s++) begin
      tick();
      chk("R10 held valid", tx_valid, 1);
      chk("R10 held type", tx_type, 1);
      chk("R10 held dst", tx_dst, home);
    end
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    for (int k = 0; k < N - 1; k++) begin
      int src;
      src = 1 + ((k + rot) % (N - 1));
      if (bad >= 0 && k == 1) begin
        case (bad % 3)
          0: send_rx(3'd2, src, ME, a ^ 16'h0100, 0);
          1: send_rx(3'd3, src, 1, a, 32'hBAD);
          default: send_rx(3'd1, src, ME, a, 0);
        endcase
        bump_err();
        chk("R8 stray dropped no done", done_valid, 0);
        chk("R8 stray counted", err_count, exp_err);
      end
      send_rx((k == dpos) ? 3'd3 : 3'd2, src, ME, a, (k == dpos) ? val : 32'hFFFF);
      if (k < N - 2) chk("R4 no early done", done_valid, 0);
    end
    chk("R4 done pulse", done_valid, 1);
    if (dpos < N - 1) begin
      chk("R6 data", done_data, val);
      chk("R6 not mem", done_from_mem, 0);
    end else begin
      chk("R7 from mem", done_from_mem, 1);
      chk("R7 zero data", done_data, 0);
    end
    chk("R5 unblock valid", tx_valid, 1);
    chk("R5 unblock type", tx_type, 4);
    chk("R5 unblock home", tx_dst, home);
    chk("R5 unblock addr", tx_addr, a);
    chk("R3 still busy", miss_ready, 0);
    tick();
    chk("R4 pulse ends", done_valid, 0);
    chk("R3 busy until unblock accepted", miss_ready, 0);
    tx_ready = 1'b1; tick(); tx_ready = 1'b0;
    chk("R3 ready after unblock", miss_ready, 1);
    chk("R3 no tx", tx_valid, 0);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 ready", miss_ready, 1);
    chk("R1 tx idle", tx_valid, 0);
    chk("R1 no done", done_valid, 0);
    chk("R1 err zero", err_count, 0);
    rst_n = 1'b1;
    tick();
    send_rx(3'd2, 1, ME, 16'h0040, 0);
    bump_err();
    chk("R8 idle message counted", err_count, exp_err);
    chk("R8 idle message no effect", miss_ready, 1);
    for (int a = 0; a < 8; a++)
      for (int dp = 0; dp < N; dp++)
        do_miss(AW'((a * 37 + dp) << OW) | AW'(a), dp, (a + dp) % 3, ((a + dp) % 2 == 0) ? a + dp : -1, a);
    chk("R8 saturated", err_count, (1 << EW) - 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule